// File: doc/BRIEF.md
# EDO DRAM access sequencer

This block turns a simple synchronous request stream into the strobe sequence of an asynchronous extended-data-out DRAM array that is 72 bits wide and addressed by 24 bits. Each request carries a word address, write data and a read/write flag. The request is accepted with a valid/ready handshake. The word address is split into a row and a column, and both are sent one after the other on a shared 12-bit address bus. Reads return data on a separate port, marked by a one-cycle valid strobe.

After an access the row stays open. A later request to the same row runs as a short page cycle: only CAS toggles and RAS stays low. A request to a different row closes the row first, waits out the precharge and then opens the new row. Writes are always early writes: WE goes low before CAS falls, so the array never drives the data pins during a write. Every timing interval is a parameter counted in clock cycles. A companion refresh engine can take over the array. It raises a request, this block closes any open row, parks every strobe high and answers with a grant that lasts as long as the request does.

Top module: `edo_seq`

## Requirements
- R1: While reset is held and for the first T_RP cycles after it, RAS, CAS, WE and OE are high (inactive), the data drivers are off, ref_gnt is low and req_ready is low. In the next cycle req_ready goes high.
- R2: The row field req_addr[23:12] is on dram_addr when RAS falls and stays unchanged across that edge. The column field req_addr[11:0] is on dram_addr when CAS falls.
- R3: Once it has been driven low, RAS stays low for at least T_RAS cycles. Once it has been raised, RAS stays high for at least T_RP cycles before it falls again.
- R4: CAS is low only while RAS is low. Each CAS low pulse lasts exactly T_CAS cycles.
- R5: A write is an early write. WE is low in the cycle before CAS falls and at the fall. At the CAS fall dq_oe is 1 and dq_out equals the request's write data. OE stays high throughout the write.
- R6: For a read, rd_valid pulses for one cycle exactly T_CAC cycles after CAS falls. rd_data is the value that dq_in held just before that edge.
- R7: A request whose row equals the open row is served without RAS rising in between.
- R8: A request to a different row makes RAS rise, and the new row is presented at the next RAS fall.
- R9: When ref_req is high, the open row is closed and ref_gnt rises. While ref_gnt is high, RAS and CAS are high, the data drivers are off and req_ready is low. ref_gnt falls in the cycle after ref_req falls.
- R10: RAS never stays low for more than RASP_LIM cycles. An idle open row is closed on its own after exactly RASP_LIM low cycles.
- R11: dq_oe is never 1 while oe_n is low. OE goes low only for reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address, row in the upper 12 bits |
| req_wdata | input | 72 | Write data |
| rd_valid | output | 1 | Read data strobe |
| rd_data | output | 72 | Read data |
| ref_req | input | 1 | Refresh engine asks for the array |
| ref_gnt | output | 1 | Array released to the refresh engine |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dq_out | output | 72 | Data driven to the array |
| dq_oe | output | 1 | Enable for the dq_out drivers |
| dq_in | input | 72 | Data returned by the array |

## Verification
The hardest case to reach is the forced close of an idle open row at the RAS low-time limit. At the default limit this takes thousands of cycles, and any request arriving in between resets the situation. The bench therefore shrinks RASP_LIM to 40, opens a row with a single read, sends nothing else and measures the exact length of the RAS low pulse. A refresh request is raised while a row is still open, so that the close-then-grant path is exercised rather than the simpler grant from idle.

// File: rtl/edo_seq.sv
module edo_seq #(
  parameter int ROW_W    = 12,
  parameter int COL_W    = 12,
  parameter int DATA_W   = 72,
  parameter int T_RP     = 2,
  parameter int T_RAS    = 3,
  parameter int T_RCD    = 1,
  parameter int T_CAS    = 1,
  parameter int T_CP     = 1,
  parameter int T_CAC    = 1,
  parameter int RASP_LIM = 5000
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic                     req_write,
  input  logic [ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]        req_wdata,
  output logic                     rd_valid,
  output logic [DATA_W-1:0]        rd_data,
  input  logic                     ref_req,
  output logic                     ref_gnt,
  output logic                     ras_n,
  output logic                     cas_n,
  output logic                     we_n,
  output logic                     oe_n,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dram_addr,
  output logic [DATA_W-1:0]        dq_out,
  output logic                     dq_oe,
  input  logic [DATA_W-1:0]        dq_in
);
  localparam int A_W      = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CNT_W    = $clog2(T_RP + T_RCD + T_CAS + T_CP + T_CAC + 2);
  localparam int RAS_W    = $clog2(RASP_LIM + 1);
  localparam int PAGE_CYC = 1 + T_CAS + T_CP;
  localparam logic [CNT_W-1:0] RP_END  = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] RCD_END = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] CAS_END = CNT_W'(T_CAS - 1);
  localparam logic [CNT_W-1:0] CP_END  = CNT_W'(T_CP - 1);
  localparam logic [CNT_W-1:0] CAC_N   = CNT_W'(T_CAC);
  localparam logic [RAS_W-1:0] RAS_MIN = RAS_W'(T_RAS - 1);
  localparam logic [RAS_W-1:0] RAS_END = RAS_W'(RASP_LIM - 1);
  localparam logic [RAS_W-1:0] PAGE_LAST = RAS_W'(RASP_LIM - PAGE_CYC - 2);

  typedef enum logic [3:0] {
    S_PRE, S_IDLE, S_ROW, S_ACT, S_COL, S_CASL, S_CASH, S_OPEN, S_GNT
  } st_t;

  st_t               st;
  logic [CNT_W-1:0]  cnt, cap_cnt;
  logic [RAS_W-1:0]  ras_cnt;
  logic [ROW_W-1:0]  open_row;
  logic [COL_W-1:0]  col_q;
  logic [DATA_W-1:0] wdata_q;
  logic              wr_q;

  wire [ROW_W-1:0] req_row = req_addr[ROW_W+COL_W-1:COL_W];
  wire [COL_W-1:0] req_col = req_addr[COL_W-1:0];
  wire row_low   = (st == S_ACT) || (st == S_COL) || (st == S_CASL) ||
                   (st == S_CASH) || (st == S_OPEN);
  wire hit       = (req_row == open_row);
  wire page_room = (ras_cnt <= PAGE_LAST);
  wire take      = req_valid && req_ready;

  assign req_ready = !ref_req && ((st == S_IDLE) || (st == S_OPEN && hit && page_room));
  assign ras_n   = !row_low;
  assign cas_n   = (st != S_CASL);
  assign we_n    = !(wr_q && ((st == S_COL) || (st == S_CASL)));
  assign dq_oe   = !we_n;
  assign dq_out  = wdata_q;
  assign oe_n    = !(row_low && !wr_q);
  assign ref_gnt = (st == S_GNT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_PRE; cnt <= '0; cap_cnt <= '0; ras_cnt <= '0;
      open_row <= '0; col_q <= '0; wdata_q <= '0; wr_q <= 1'b0;
      dram_addr <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_valid <= 1'b0;
      if (cap_cnt != '0) begin
        cap_cnt <= cap_cnt - 1'b1;
        if (cap_cnt == CNT_W'(1)) begin
          rd_valid <= 1'b1;
          rd_data  <= dq_in;
        end
      end
      ras_cnt <= row_low ? ras_cnt + 1'b1 : '0;
      cnt <= cnt + 1'b1;
      case (st)
        S_PRE:  if (cnt == RP_END) begin st <= S_IDLE; cnt <= '0; end
        S_IDLE: begin
          if (ref_req) st <= S_GNT;
          else if (take) begin
            wr_q <= req_write; wdata_q <= req_wdata; col_q <= req_col;
            open_row <= req_row; dram_addr <= A_W'(req_row); st <= S_ROW;
          end
        end
        S_ROW:  begin st <= S_ACT; cnt <= '0; end
        S_ACT:  if (cnt == RCD_END) begin dram_addr <= A_W'(col_q); st <= S_COL; end
        S_COL:  begin
          st <= S_CASL; cnt <= '0;
          if (!wr_q) cap_cnt <= CAC_N;
        end
        S_CASL: if (cnt == CAS_END) begin st <= S_CASH; cnt <= '0; end
        S_CASH: if (cnt == CP_END) begin st <= S_OPEN; cnt <= '0; end
        S_OPEN: begin
          if (take) begin
            wr_q <= req_write; wdata_q <= req_wdata; col_q <= req_col;
            dram_addr <= A_W'(req_col); st <= S_COL;
          end else if ((ras_cnt >= RAS_END) ||
                       ((ref_req || req_valid) && ras_cnt >= RAS_MIN)) begin
            st <= S_PRE; cnt <= '0;
          end
        end
        S_GNT:  if (!ref_req) begin st <= S_PRE; cnt <= '0; end
        default: st <= S_PRE;
      endcase
    end
  end
endmodule

// File: rtl/edo_seq_chk.sv
module edo_seq_chk #(
  parameter int A_W      = 12,
  parameter int T_RP     = 2,
  parameter int T_RAS    = 3,
  parameter int RASP_LIM = 5000
) (
  input logic           clk,
  input logic           rst_n,
  input logic           ras_n,
  input logic           cas_n,
  input logic           we_n,
  input logic           oe_n,
  input logic           dq_oe,
  input logic           ref_gnt,
  input logic [A_W-1:0] dram_addr
);
  localparam int CW = $clog2(RASP_LIM + T_RP + T_RAS + 2);
  logic [CW-1:0] hi_cnt, lo_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_cnt <= '0; lo_cnt <= '0;
    end else begin
      lo_cnt <= ras_n ? '0 : lo_cnt + 1'b1;
      if (!ras_n) hi_cnt <= '0;
      else if (hi_cnt != {CW{1'b1}}) hi_cnt <= hi_cnt + 1'b1;
    end
  end

  assert_precharge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> hi_cnt >= CW'(T_RP));
  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> lo_cnt >= CW'(T_RAS));
  assert_ras_limit_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !ras_n |-> lo_cnt < CW'(RASP_LIM));
  assert_cas_in_row_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cas_n |-> !ras_n);
  assert_we_setup_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cas_n) && !we_n) |-> $past(!we_n));
  assert_no_fight_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !dq_oe);
  assert_grant_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ref_gnt |-> (ras_n && cas_n && !dq_oe));
  assert_row_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n) |-> $stable(dram_addr));
endmodule

bind edo_seq edo_seq_chk #(.A_W(A_W), .T_RP(T_RP), .T_RAS(T_RAS), .RASP_LIM(RASP_LIM)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .ref_gnt(ref_gnt), .dram_addr(dram_addr)
);

// File: tb/edo_seq_test.sv
`timescale 1ns/1ps
module edo_seq_test;
  localparam int T_RP = 2, T_RAS = 3, T_CAS = 1, T_CAC = 1, LIM = 40;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_write = 0, ref_req = 0;
  logic [23:0] req_addr = '0;
  logic [71:0] req_wdata = '0, dq_in = '0;
  logic req_ready, rd_valid, ref_gnt, ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [71:0] rd_data, dq_out;
  logic [11:0] dram_addr;

  int errors = 0, checks = 0;

  edo_seq #(.T_RP(T_RP), .T_RAS(T_RAS), .T_CAS(T_CAS), .T_CAC(T_CAC), .RASP_LIM(LIM)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_gnt(ref_gnt),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .oe_n(oe_n), .dram_addr(dram_addr),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in));

  always #10 clk = ~clk;

  // array model and strobe monitor
  logic [71:0] mem [logic [23:0]];
  int ras_rises, low_run, high_run, last_low, last_high, cas_run, last_cas, since_cas, last_lat;
  logic [11:0] row_lat, col_lat;
  logic we_fall, we_before, oe_fall, oen_fall, p_ras, p_cas, p_we;
  logic [71:0] dq_fall;

  function automatic logic [71:0] pattern(logic [23:0] k);
    return {24'hC0FFEE, k, ~k};
  endfunction

  always @(negedge clk) begin
    if (!rst_n) begin
      ras_rises = 0; low_run = 0; high_run = 0; last_low = 0; last_high = 0;
      cas_run = 0; last_cas = 0; since_cas = 0; last_lat = -1;
      p_ras = 1; p_cas = 1; p_we = 1;
    end else begin
      if (!ras_n) begin
        if (p_ras) begin last_high = high_run; row_lat = dram_addr; end
        low_run++; high_run = 0;
      end else begin
        if (!p_ras) begin last_low = low_run; ras_rises++; end
        high_run++; low_run = 0;
      end
      if (!cas_n && p_cas) begin
        col_lat = dram_addr; we_fall = we_n; we_before = p_we;
        oe_fall = dq_oe; oen_fall = oe_n; dq_fall = dq_out; since_cas = 0;
        if (!we_n) mem[{row_lat, col_lat}] = dq_out;
        else dq_in = mem.exists({row_lat, col_lat}) ? mem[{row_lat, col_lat}]
                                                     : pattern({row_lat, col_lat});
      end else since_cas++;
      if (cas_n && !p_cas) last_cas = cas_run;
      cas_run = !cas_n ? cas_run + 1 : 0;
      if (rd_valid) last_lat = since_cas;
      p_ras = ras_n; p_cas = cas_n; p_we = we_n;
    end
  end

  task automatic tick(); @(negedge clk); #2; endtask

  task automatic chk(bit ok, string tag, logic [71:0] act, logic [71:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(bit wr, logic [23:0] a, logic [71:0] d);
    int g = 0;
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; #1;
    while (!req_ready && g < 200) begin tick(); g++; end
    tick(); req_valid = 0;
  endtask

  task automatic settle(); for (int i = 0; i < 6; i++) tick(); endtask

  task automatic read_expect(logic [23:0] a, logic [71:0] exp, string tag);
    int g = 0;
    issue(0, a, '0);
    while (!rd_valid && g < 30) begin tick(); g++; end
    chk(rd_valid, tag, rd_valid, 1);
    chk(rd_data == exp, tag, rd_data, exp);
    settle();
  endtask

  task automatic t_reset();
    chk({ras_n, cas_n, we_n, oe_n} == 4'hF && !dq_oe && !ref_gnt, "R1 strobes idle",
        {ras_n, cas_n, we_n, oe_n, dq_oe, ref_gnt}, 6'b111100);
    chk(!req_ready, "R1 ready in reset", req_ready, 0);
    for (int i = 0; i < T_RP; i++) begin
      tick();
      if (i < T_RP - 1) chk(!req_ready, "R1 ready during precharge", req_ready, 0);
      else chk(req_ready, "R1 ready after precharge", req_ready, 1);
    end
  endtask

  task automatic t_write_read(logic [23:0] a, logic [71:0] d);
    issue(1, a, d); settle();
    chk(row_lat == a[23:12], "R2 row at RAS fall", row_lat, a[23:12]);
    chk(col_lat == a[11:0], "R2 column at CAS fall", col_lat, a[11:0]);
    chk(!we_fall && !we_before, "R5 WE low before CAS", {we_before, we_fall}, 0);
    chk(oe_fall && dq_fall == d, "R5 write data driven", dq_fall, d);
    chk(oen_fall, "R5 OE high in write", oen_fall, 1);
    read_expect(a, d, "R6 read back");
    chk(last_lat == T_CAC, "R6 capture latency", last_lat, T_CAC);
    chk(oen_fall == 0 && oe_fall == 0, "R11 read OE low drivers off", {oen_fall, oe_fall}, 0);
    chk(last_cas == T_CAS, "R4 CAS pulse width", last_cas, T_CAS);
  endtask

  task automatic t_page(logic [23:0] a);
    int r0 = ras_rises;
    read_expect(a, pattern(a), "R7 page read data");
    chk(ras_rises == r0, "R7 no RAS rise on hit", ras_rises, r0);
  endtask

  task automatic t_miss(logic [23:0] a);
    int r0 = ras_rises;
    read_expect(a, pattern(a), "R8 miss read data");
    chk(ras_rises == r0 + 1, "R8 one RAS rise", ras_rises, r0 + 1);
    chk(row_lat == a[23:12], "R8 new row", row_lat, a[23:12]);
    chk(last_high >= T_RP, "R3 precharge length", last_high, T_RP);
    chk(last_low >= T_RAS, "R3 RAS low length", last_low, T_RAS);
  endtask

  task automatic t_refresh();
    int g = 0;
    chk(!ras_n, "R9 row open before refresh", ras_n, 0);
    ref_req = 1; #1;
    while (!ref_gnt && g < 50) begin tick(); g++; end
    chk(ref_gnt, "R9 grant raised", ref_gnt, 1);
    req_valid = 1; req_addr = 24'h000123; #1;
    chk(ras_n && cas_n && !dq_oe, "R9 bus released", {ras_n, cas_n, dq_oe}, 3'b110);
    chk(!req_ready, "R9 no requests in grant", req_ready, 0);
    tick(); tick();
    chk(ref_gnt && ras_n, "R9 grant held", {ref_gnt, ras_n}, 2'b11);
    req_valid = 0; ref_req = 0; tick();
    chk(!ref_gnt, "R9 grant dropped", ref_gnt, 0);
  endtask

  task automatic t_timeout(logic [23:0] a);
    int g = 0;
    read_expect(a, pattern(a), "R10 read before timeout");
    while (!ras_n && g < 200) begin tick(); g++; end
    tick();
    chk(last_low == LIM, "R10 idle row closes at limit", last_low, LIM);
  endtask

  initial begin
    #(20 * 100000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    tick(); tick();
    rst_n = 1; #1;
    t_reset();
    t_write_read(24'h3A5_0F1, 72'h12_3456_789A_BCDE_F012);
    t_page(24'h3A5_777);
    t_miss(24'h0C0_010);
    t_refresh();
    read_expect(24'h3A5_0F1, 72'h12_3456_789A_BCDE_F012, "R9 data after refresh");
    t_write_read(24'hFFF_FFF, {72{1'b1}});
    t_timeout(24'h800_001);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule